// File: doc/BRIEF.md
# Parallel Receive Channel with Backpressure

This block takes words from an external device on a parallel bus and holds them in an internal store that a host-side consumer drains. The device marks each word with a valid strobe, which is sampled on the rising clock edge. An accepted word passes through a short register pipeline before it is written into the store. The whole block runs in one clock domain.

To hold off the device early, the block raises a not-ready warning when little room is left. Room is measured in bytes against the nominal depth, and words still in the pipeline count as occupied. Beyond the nominal depth the store has a hidden reserve. The reserve is sized so that a fixed number of further strobes is still absorbed after the warning first goes high. A strobe that arrives when the store and pipeline together are completely full is dropped, and a sticky overflow flag records it.

On the host side the oldest word is shown together with a valid flag and a word count. A single-cycle pop removes that word.

Top module: `rx_backpressure_chan`

## Requirements
- R1: After reset, `not_ready`, `overflow` and `head_valid` are 0 and `level` is 0.
- R2: A word on `in_data` is accepted at a rising edge where `in_valid` is 1 and occupancy is below capacity. It is written into the store at the second following edge. Words appear at `head_data` in acceptance order, and nothing is captured while `in_valid` is 0.
- R3: Occupancy counts the words in the pipeline plus the words in the store. Free bytes equal BYTES_PER_WORD × (DEPTH − occupancy), or 0 when occupancy is at or above DEPTH. `not_ready` is 1 exactly when free bytes ≤ THRESH_BYTES, so it drops as soon as free bytes exceed the threshold again.
- R4: Capacity is DEPTH + SLACK_STROBES − THRESH_BYTES/BYTES_PER_WORD words. With no pops, exactly SLACK_STROBES further strobes are stored after `not_ready` first reads 1.
- R5: A strobe that arrives while occupancy equals capacity is dropped, even if a pop happens in the same cycle. `overflow` is 1 from the following edge and holds until reset.
- R6: `head_data` shows the oldest stored word while `head_valid` is 1. A pop at an edge where `head_valid` is 1 removes that word. `level` equals the number of words in the store.
- R7: A pop at an edge where `head_valid` is 0 has no effect: the store stays empty and `level` stays 0.
- R8: When a pipeline write and an effective pop happen at the same edge, `level` does not change.
- R9: Reset during operation empties the store and the pipeline and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Word from the device |
| in_valid | input | 1 | Strobe marking `in_data` valid |
| not_ready | output | 1 | Warning that free space is at or below the threshold |
| overflow | output | 1 | Sticky flag: a strobe was dropped |
| head_data | output | DATA_W | Oldest stored word |
| head_valid | output | 1 | Store is not empty |
| pop | input | 1 | Remove the head word |
| level | output | $clog2(CAP+1) | Words currently in the store |

## Verification
The bench builds the block with DEPTH=16, THRESH_BYTES=8 and SLACK_STROBES=8, which gives a 4-word threshold, a 4-word reserve and a capacity of 20. At this size a single fill runs every occupancy value from empty, through the warning point and the reserve, to overflow. The exact count of strobes absorbed after the warning is measured directly. A drain, extra pops on an empty store and several mixed strobe/pop patterns then cover every level downward, including the cycles where a write and a pop coincide.

// File: rtl/rxbp_pkg.sv
package rxbp_pkg;

  // Free space in bytes relative to the nominal depth, clamped at zero.
  function automatic int unsigned free_bytes(input int unsigned occ,
                                             input int unsigned depth,
                                             input int unsigned bpw);
    return (occ >= depth) ? 0 : (depth - occ) * bpw;
  endfunction

  // Hidden reserve beyond the nominal depth so that `slack` strobes fit after the warning.
  function automatic int unsigned reserve_words(input int unsigned slack,
                                                input int unsigned thresh_bytes,
                                                input int unsigned bpw);
    int unsigned tw;
    tw = thresh_bytes / bpw;
    return (slack > tw) ? slack - tw : 0;
  endfunction

  // Circular pointer advance for a store of arbitrary size.
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned size);
    return (p + 1 >= size) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rxbp_in_pipe.sv
module rxbp_in_pipe #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic         v_q [STAGES];
  logic [W-1:0] d_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0;
          d_q[0] <= '0;
        end else begin
          v_q[0] <= in_v;
          d_q[0] <= in_d;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
  end

  assign out_v = v_q[STAGES-1];
  assign out_d = d_q[STAGES-1];
endmodule

// File: rtl/rxbp_store.sv
module rxbp_store #(
  parameter int W   = 16,
  parameter int CAP = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       pop,
  output logic                       pop_ok,
  output logic [W-1:0]               head_data,
  output logic                       head_valid,
  output logic [$clog2(CAP+1)-1:0]   count
);
  import rxbp_pkg::*;
  localparam int PTR_W = (CAP > 1) ? $clog2(CAP) : 1;
  localparam int CNT_W = $clog2(CAP+1);

  logic [W-1:0]     mem [CAP];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  assign head_valid = (cnt_q != '0);
  assign pop_ok     = pop && head_valid;
  assign head_data  = mem[rd_ptr];
  assign count      = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en)  wr_ptr <= PTR_W'(ptr_next(int'(wr_ptr), CAP));
      if (pop_ok) rd_ptr <= PTR_W'(ptr_next(int'(rd_ptr), CAP));
      case ({wr_en, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rxbp_occ.sv
module rxbp_occ #(
  parameter int DEPTH        = 16,
  parameter int CAP          = 20,
  parameter int THRESH_BYTES = 8,
  parameter int BPW          = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     pop_ok,
  output logic                     acc,
  output logic [$clog2(CAP+1)-1:0] occ,
  output logic                     not_ready,
  output logic                     overflow
);
  import rxbp_pkg::*;
  localparam int OCC_W = $clog2(CAP+1);

  logic [OCC_W-1:0] occ_q;
  logic             ovf_q;
  logic             full;

  assign full      = (int'(occ_q) == CAP);
  assign acc       = in_valid && !full;
  assign occ       = occ_q;
  assign not_ready = free_bytes(int'(occ_q), DEPTH, BPW) <= THRESH_BYTES;
  assign overflow  = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      case ({acc, pop_ok})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
      if (in_valid && full) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_backpressure_chan.sv
module rx_backpressure_chan #(
  parameter int DATA_W        = 16,
  parameter int DEPTH         = 256,
  parameter int THRESH_BYTES  = 32,
  parameter int SLACK_STROBES = 32,
  parameter int PIPE_STAGES   = 2,
  localparam int BPW   = DATA_W / 8,
  localparam int CAP   = DEPTH + rxbp_pkg::reserve_words(SLACK_STROBES, THRESH_BYTES, BPW),
  localparam int LVL_W = $clog2(CAP+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              not_ready,
  output logic              overflow,
  output logic [DATA_W-1:0] head_data,
  output logic              head_valid,
  input  logic              pop,
  output logic [LVL_W-1:0]  level
);
  logic              acc;
  logic              pop_ok;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [LVL_W-1:0]  occ;

  rxbp_occ #(
    .DEPTH(DEPTH), .CAP(CAP), .THRESH_BYTES(THRESH_BYTES), .BPW(BPW)
  ) u_occ (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pop_ok(pop_ok),
    .acc(acc), .occ(occ), .not_ready(not_ready), .overflow(overflow)
  );

  rxbp_in_pipe #(.W(DATA_W), .STAGES(PIPE_STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(acc), .in_d(in_data),
    .out_v(wr_en), .out_d(wr_data)
  );

  rxbp_store #(.W(DATA_W), .CAP(CAP)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pop(pop), .pop_ok(pop_ok), .head_data(head_data),
    .head_valid(head_valid), .count(level)
  );
endmodule

// File: rtl/rxbp_chk.sv
module rxbp_chk #(
  parameter int CAP   = 20,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             pop,
  input logic             acc,
  input logic             wr_en,
  input logic             pop_ok,
  input logic [LVL_W-1:0] occ,
  input logic [LVL_W-1:0] level,
  input logic             not_ready,
  input logic             overflow,
  input logic             head_valid
);
  // R2: an accepted strobe reaches the store two edges later
  a_r2_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##2 wr_en);
  // R3: the warning only rises after an acceptance
  a_r3_rise_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(not_ready) |-> $past(acc));
  // R3: the warning only falls after an effective pop
  a_r3_fall_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(not_ready) |-> $past(pop_ok));
  // R5: overflow is sticky
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R5: overflow rises only after a rejected strobe
  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(in_valid && !acc));
  // R5: occupancy never exceeds capacity
  a_r5_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= CAP);
  // R7: a pop on an empty store is not effective
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !head_valid) |-> !pop_ok);
  // R8: simultaneous write and pop leave the level unchanged
  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pop_ok) |=> $stable(level));
endmodule

bind rx_backpressure_chan rxbp_chk #(.CAP(CAP), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pop(pop), .acc(acc),
  .wr_en(wr_en), .pop_ok(pop_ok), .occ(occ), .level(level),
  .not_ready(not_ready), .overflow(overflow), .head_valid(head_valid)
);

// File: tb/tb_rx_backpressure_chan.sv
module tb_rx_backpressure_chan;
  localparam int DW     = 16;
  localparam int DEPTH  = 16;
  localparam int THR    = 8;
  localparam int SLACK  = 8;
  localparam int BPWB   = DW / 8;
  localparam int TW     = THR / BPWB;
  localparam int CAPM   = DEPTH + SLACK - TW;
  localparam int LW     = $clog2(CAPM+1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          pop = 1'b0;
  logic          not_ready, overflow, head_valid;
  logic [DW-1:0] head_data;
  logic [LW-1:0] level;

  int checks = 0;
  int errors = 0;

  // model state
  logic [DW-1:0] q[$];
  int            m_occ = 0;
  bit            m_ovf = 1'b0;
  bit            p0v = 1'b0, p1v = 1'b0;
  logic [DW-1:0] p0d = '0, p1d = '0;
  bit            last_acc;
  bit            last_both;
  int            prev_level;

  always #10 clk = ~clk;

  rx_backpressure_chan #(
    .DATA_W(DW), .DEPTH(DEPTH), .THRESH_BYTES(THR),
    .SLACK_STROBES(SLACK), .PIPE_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .not_ready(not_ready), .overflow(overflow), .head_data(head_data),
    .head_valid(head_valid), .pop(pop), .level(level)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_nr();
    int fb;
    fb = (m_occ >= DEPTH) ? 0 : (DEPTH - m_occ) * BPWB;
    return fb <= THR;
  endfunction

  task automatic compare_all();
    chk("R3", "not_ready", not_ready, exp_nr());
    chk("R5", "overflow", overflow, m_ovf);
    chk("R6", "head_valid", head_valid, q.size() != 0);
    chk("R6", "level", level, q.size());
    if (q.size() != 0) chk("R2", "head_data", head_data, q[0]);
    if (last_both) chk("R8", "level on write+pop", level, prev_level);
  endtask

  task automatic model_reset();
    q.delete();
    m_occ = 0; m_ovf = 1'b0;
    p0v = 1'b0; p1v = 1'b0; p0d = '0; p1d = '0;
  endtask

  task automatic step(input bit v, input logic [DW-1:0] d, input bit p);
    bit acc, popok, wr;
    @(negedge clk);
    in_valid = v; in_data = d; pop = p;
    prev_level = q.size();
    @(posedge clk);
    acc   = v && (m_occ < CAPM);
    popok = p && (q.size() != 0);
    wr    = p1v;
    if (v && !acc) m_ovf = 1'b1;
    if (popok) void'(q.pop_front());
    if (wr) q.push_back(p1d);
    p1v = p0v; p1d = p0d;
    p0v = acc; p0d = d;
    m_occ = m_occ + (acc ? 1 : 0) - (popok ? 1 : 0);
    last_acc  = acc;
    last_both = wr && popok;
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; pop = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    last_both = 1'b0;
  endtask

  initial begin : watchdog
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int slack_cnt;
    last_both = 1'b0;
    do_reset();
    // R1: reset state
    chk("R1", "not_ready", not_ready, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "head_valid", head_valid, 0);
    chk("R1", "level", level, 0);

    // R2/R4/R5: fill without pops past capacity
    slack_cnt = 0;
    for (int i = 0; i < CAPM + 3; i++) begin
      bit nr_seen;
      nr_seen = not_ready;
      step(1'b1, 16'hA000 + DW'(i), 1'b0);
      if (nr_seen && last_acc) slack_cnt++;
    end
    chk("R4", "strobes stored after warning", slack_cnt, SLACK);
    chk("R5", "overflow after excess strobes", overflow, 1);
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    chk("R4", "level at capacity", level, CAPM);

    // R5: strobe at full with a same-cycle pop is still dropped
    step(1'b1, 16'hBEEF, 1'b1);
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    chk("R5", "dropped despite pop", level, CAPM - 1);

    // R3/R6: drain, then extra pops on empty
    for (int i = 0; i < CAPM + 4; i++) step(1'b0, '0, 1'b1);
    // R7: pops on empty store have no effect
    chk("R7", "level after empty pops", level, 0);
    chk("R7", "head_valid after empty pops", head_valid, 0);
    step(1'b1, 16'h1234, 1'b1);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    chk("R7", "word survives earlier empty pops", head_data, 16'h1234);
    chk("R7", "level one", level, 1);

    // R9: reset clears the sticky flag and the contents
    do_reset();
    chk("R9", "overflow cleared", overflow, 0);
    chk("R9", "level cleared", level, 0);
    chk("R9", "not_ready cleared", not_ready, 0);

    // R2/R3/R6/R8: mixed strobe and pop patterns
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 60; i++) begin
        bit v, p;
        v = ((i + k) % 3) != 0 || (k == 2 && i < 30);
        p = (k == 0) ? (i % 2 == 1) :
            (k == 1) ? (i % 4 == 3) :
            (k == 2) ? (i >= 30) : ((i * 7) % 5 < 2);
        step(v, DW'(k * 16'h1000 + i * 16'h0101), p);
      end
    end
    for (int i = 0; i < CAPM + 4; i++) step(1'b0, '0, 1'b1);
    chk("R6", "drained at end", level, 0);

    // R9: reset in the middle of traffic
    for (int i = 0; i < 5; i++) step(1'b1, DW'(i), 1'b0);
    do_reset();
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    chk("R9", "pipeline flushed by reset", level, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule